// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block sits between instruction decode and the execute stage. When a decoded scalar instruction names at least one operand that has been marked as a vector, the sequencer holds the program counter and turns that one instruction into a series of element operations, issuing at most one per cycle. Vector operands step through contiguous register numbers; scalar operands keep the register named in the instruction. The walk is two-level: an outer loop over the vector length and an inner loop over a sub-vector group of one to four sub-elements.

Each element is gated by one bit of a predicate mask, which may be inverted before use. A masked element is either skipped silently or issued as a "write zero" operation, depending on the zeroing mode. A fail-on-first mode ends the loop early when an element result is zero and reports the shortened vector length. The loop position is held in an element offset that stays put when an element faults. A trap handler can read it, and the loop then resumes from that point when the instruction is issued again.

Top module: `elem_loop_seq`

## Requirements
- R1: `pc_hold` rises in the cycle after an accepted `start` and stays high until the loop ends. When the loop ends normally or early, `pc_hold` falls in the same cycle that `done` is high for exactly one cycle.
- R2: For each issued operation, a vector operand's register number is its base plus `op_elem*S + op_sub`, modulo the register space, where S is the sub-vector count. A scalar operand's register number is its base unchanged.
- R3: A loop starts at element min(offset, VL-1), where offset is the current `srcoffs` value. While the block is idle, `ofs_wr` loads `ofs_wr_val` into both offsets.
- R4: With predication enabled and zeroing off, an element whose effective predicate bit is 0 issues nothing, and the loop moves on to the next element.
- R5: With zeroing on, an element whose effective predicate bit is 0 issues all S of its sub-operations with `op_zero`=1. Every other issued operation has `op_zero`=0.
- R6: The effective predicate bit of element i is `pred_mask[i] ^ pred_inv` when `pred_en`=1, and 1 when `pred_en`=0.
- R7: `subvl_in` encodes S-1 (0 means S=1, 3 means S=4). Each active element issues sub-operations 0 to S-1 in order, and all of them share that element's predicate bit.
- R8: If `ex_fault` is high when an operation is accepted, the offsets keep that element's index. `trap` then pulses for one cycle, `pc_hold` falls, and `done` is not raised.
- R9: When the loop completes all VL elements, both offsets return to 0, `vl_new` equals VL and `vl_cut` is 0.
- R10: With fail-on-first set, if `ex_zero` is high when an active operation of element i is accepted, no further operation issues. `vl_new` then becomes i, `vl_cut` becomes 1, and the offsets return to 0.
- R11: With fail-on-first and zeroing both set, the first masked element ends the loop without issuing, and `vl_new` is set to its index. With fail-on-first and zeroing off, masked elements never end the loop.
- R12: While `issue_valid` is high and `issue_ready` is low, the operation fields stay unchanged and the loop does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Decoded instruction with a tagged operand; taken only when idle |
| vl_in | input | VLW | Vector length, 1 to XLEN |
| subvl_in | input | 2 | Sub-vector count minus one |
| pred_en | input | 1 | Apply the predicate mask |
| pred_inv | input | 1 | Complement the mask bit before use |
| zeroing | input | 1 | Masked elements write zero instead of being skipped |
| ffirst | input | 1 | Fail-on-first mode |
| pred_mask | input | XLEN | Predicate bits, one per element |
| rd_in | input | REGW | Destination base register |
| rs1_in | input | REGW | First source base register |
| rs2_in | input | REGW | Second source base register |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | First source is a vector |
| rs2_vec | input | 1 | Second source is a vector |
| ofs_wr | input | 1 | Load the offsets while idle |
| ofs_wr_val | input | IDXW | Offset value to load |
| issue_ready | input | 1 | Execute stage accepts the operation |
| ex_zero | input | 1 | Result of the accepted operation is zero (either sign) |
| ex_fault | input | 1 | Accepted operation raised an exception |
| pc_hold | output | 1 | Program counter must not advance |
| issue_valid | output | 1 | An element operation is offered |
| op_rd | output | REGW | Destination register of the operation |
| op_rs1 | output | REGW | First source register |
| op_rs2 | output | REGW | Second source register |
| op_elem | output | IDXW | Element index |
| op_sub | output | 2 | Sub-element index |
| op_zero | output | 1 | Write zero to the destination instead of the result |
| srcoffs | output | IDXW | Source element offset |
| destoffs | output | IDXW | Destination element offset |
| done | output | 1 | One-cycle pulse as the program counter is released |
| trap | output | 1 | One-cycle pulse after a faulting element |
| vl_new | output | VLW | Vector length in effect after the last loop |
| vl_cut | output | 1 | Last loop was shortened by fail-on-first |

## Verification
`pc_hold` is registered, so it rises one cycle after the edge that takes `start`. The operation fields and `issue_valid` are combinational from the loop state, so they are valid in the same cycle in which the handshake completes. `done`, `trap`, `vl_new`, `vl_cut` and the offsets all change on the edge that accepts the final or faulting operation, or that processes the terminating masked element, so they are visible one cycle later. The bench drives inputs and samples outputs on falling edges. It answers each offered operation before the rising edge that consumes it, and it reads the completion outputs at the first falling edge after that edge.

// File: rtl/elseq_pkg.sv
package elseq_pkg;

    localparam int SUB_ENC_W = 2;
    localparam int N_OPND    = 3;

    typedef struct packed {
        logic pen;
        logic inv;
        logic zer;
        logic ff;
    } pmode_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_HOLD,
        ACT_NEXT_SUB,
        ACT_NEXT_ELEM,
        ACT_DONE,
        ACT_CUT,
        ACT_TRAP
    } act_t;

    function automatic logic [SUB_ENC_W:0] sub_count(input logic [SUB_ENC_W-1:0] enc);
        return {1'b0, enc} + 1'b1;
    endfunction

endpackage

// File: rtl/elseq_pred.sv
module elseq_pred
    import elseq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] mask,
    input  logic [IDXW-1:0] idx,
    input  pmode_t          mode,
    output logic            active
);
    logic raw_bit;

    always_comb begin
        raw_bit = mask[idx];
        active  = mode.pen ? (raw_bit ^ mode.inv) : 1'b1;
    end

endmodule

// File: rtl/elseq_opgen.sv
module elseq_opgen
    import elseq_pkg::*;
#(
    parameter int REGW = 7,
    parameter int IDXW = 5
) (
    input  logic [N_OPND-1:0][REGW-1:0] base,
    input  logic [N_OPND-1:0]           vec,
    input  logic [IDXW-1:0]             idx,
    input  logic [SUB_ENC_W-1:0]        sub,
    input  logic [SUB_ENC_W-1:0]        subenc,
    output logic [N_OPND-1:0][REGW-1:0] regs
);
    localparam int SW = IDXW + SUB_ENC_W + 1;
    localparam int AW = (SW > REGW) ? SW : REGW;

    logic [SW-1:0] step;
    logic [AW-1:0] step_w;

    always_comb begin
        step   = SW'(idx) * SW'(sub_count(subenc)) + SW'(sub);
        step_w = AW'(step);
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic [AW-1:0] sum;
        always_comb begin
            sum     = AW'(base[g]) + step_w;
            regs[g] = vec[g] ? sum[REGW-1:0] : base[g];
        end
    end

endmodule

// File: rtl/elseq_ctrl.sv
module elseq_ctrl
    import elseq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN),
    parameter int VLW  = IDXW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [VLW-1:0]       vl_in,
    input  logic [VLW-1:0]       ctx_vl,
    input  logic [SUB_ENC_W-1:0] ctx_subenc,
    input  pmode_t               ctx_mode,
    input  logic                 pbit,
    input  logic                 ofs_wr,
    input  logic [IDXW-1:0]      ofs_wr_val,
    input  logic                 issue_ready,
    input  logic                 ex_zero,
    input  logic                 ex_fault,
    output logic                 busy,
    output logic [IDXW-1:0]      idx,
    output logic [SUB_ENC_W-1:0] sub,
    output logic                 issue_valid,
    output logic                 op_zero,
    output logic                 done,
    output logic                 trap,
    output logic [VLW-1:0]       vl_new,
    output logic                 vl_cut
);
    act_t          act;
    logic          last_elem;
    logic          last_sub;
    logic          zterm;
    logic          skip;
    logic [IDXW-1:0] start_idx;

    always_comb begin
        last_elem = ({1'b0, idx} == (ctx_vl - 1'b1));
        last_sub  = (sub == ctx_subenc);
        zterm     = !pbit && ctx_mode.zer && ctx_mode.ff;
        skip      = !pbit && !ctx_mode.zer;
        issue_valid = busy && !zterm && !skip;
        op_zero     = !pbit;

        if ({1'b0, idx} >= vl_in) start_idx = IDXW'(vl_in - 1'b1);
        else                      start_idx = idx;

        if (!busy)                               act = ACT_IDLE;
        else if (zterm)                          act = ACT_CUT;
        else if (skip)                           act = last_elem ? ACT_DONE : ACT_NEXT_ELEM;
        else if (!issue_ready)                   act = ACT_HOLD;
        else if (ex_fault)                       act = ACT_TRAP;
        else if (ctx_mode.ff && ex_zero && pbit) act = ACT_CUT;
        else if (!last_sub)                      act = ACT_NEXT_SUB;
        else if (last_elem)                      act = ACT_DONE;
        else                                     act = ACT_NEXT_ELEM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            sub    <= '0;
            done   <= 1'b0;
            trap   <= 1'b0;
            vl_new <= '0;
            vl_cut <= 1'b0;
        end else begin
            done <= 1'b0;
            trap <= 1'b0;
            unique case (act)
                ACT_IDLE: begin
                    if (start) begin
                        busy <= 1'b1;
                        idx  <= start_idx;
                        sub  <= '0;
                    end else if (ofs_wr) begin
                        idx  <= ofs_wr_val;
                    end
                end
                ACT_HOLD: begin
                end
                ACT_NEXT_SUB: begin
                    sub <= sub + 1'b1;
                end
                ACT_NEXT_ELEM: begin
                    idx <= idx + 1'b1;
                    sub <= '0;
                end
                ACT_DONE: begin
                    busy   <= 1'b0;
                    idx    <= '0;
                    sub    <= '0;
                    done   <= 1'b1;
                    vl_new <= ctx_vl;
                    vl_cut <= 1'b0;
                end
                ACT_CUT: begin
                    busy   <= 1'b0;
                    idx    <= '0;
                    sub    <= '0;
                    done   <= 1'b1;
                    vl_new <= {1'b0, idx};
                    vl_cut <= 1'b1;
                end
                ACT_TRAP: begin
                    busy <= 1'b0;
                    sub  <= '0;
                    trap <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // R1: the done pulse coincides with the released program counter
    p_done_release_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R1: hold only drops through completion or a trap
    p_hold_end_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || trap));

    // R8: a faulting element keeps its offset
    p_fault_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && ex_fault) |=> (trap && !done && idx == $past(idx)));

    // R9: offsets are cleared when the loop ends
    p_ofs_clear_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (idx == '0 && sub == '0));

    // R10: a shortened length is below the requested one
    p_cut_short_r10: assert property (@(posedge clk) disable iff (rst)
        (done && vl_cut) |-> (vl_new < ctx_vl));

    // R7: the sub-element index stays inside the group
    p_sub_range_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sub <= ctx_subenc));

    // R12: a refused offer leaves the loop where it was
    p_stall_r12: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_ready) |=> (busy && idx == $past(idx) && sub == $past(sub)));

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elseq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 7,
    parameter int IDXW = $clog2(XLEN),
    parameter int VLW  = IDXW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [VLW-1:0]       vl_in,
    input  logic [1:0]           subvl_in,
    input  logic                 pred_en,
    input  logic                 pred_inv,
    input  logic                 zeroing,
    input  logic                 ffirst,
    input  logic [XLEN-1:0]      pred_mask,
    input  logic [REGW-1:0]      rd_in,
    input  logic [REGW-1:0]      rs1_in,
    input  logic [REGW-1:0]      rs2_in,
    input  logic                 rd_vec,
    input  logic                 rs1_vec,
    input  logic                 rs2_vec,
    input  logic                 ofs_wr,
    input  logic [IDXW-1:0]      ofs_wr_val,
    input  logic                 issue_ready,
    input  logic                 ex_zero,
    input  logic                 ex_fault,
    output logic                 pc_hold,
    output logic                 issue_valid,
    output logic [REGW-1:0]      op_rd,
    output logic [REGW-1:0]      op_rs1,
    output logic [REGW-1:0]      op_rs2,
    output logic [IDXW-1:0]      op_elem,
    output logic [1:0]           op_sub,
    output logic                 op_zero,
    output logic [IDXW-1:0]      srcoffs,
    output logic [IDXW-1:0]      destoffs,
    output logic                 done,
    output logic                 trap,
    output logic [VLW-1:0]       vl_new,
    output logic                 vl_cut
);
    logic [VLW-1:0]                  ctx_vl;
    logic [SUB_ENC_W-1:0]            ctx_subenc;
    pmode_t                          ctx_mode;
    logic [XLEN-1:0]                 ctx_mask;
    logic [N_OPND-1:0][REGW-1:0]     ctx_base;
    logic [N_OPND-1:0]               ctx_vec;
    logic [N_OPND-1:0][REGW-1:0]     regs;
    logic                            busy;
    logic                            pbit;
    logic [IDXW-1:0]                 idx;
    logic [SUB_ENC_W-1:0]            sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_vl     <= VLW'(1);
            ctx_subenc <= '0;
            ctx_mode   <= '0;
            ctx_mask   <= '0;
            ctx_base   <= '0;
            ctx_vec    <= '0;
        end else if (start && !busy) begin
            ctx_vl     <= vl_in;
            ctx_subenc <= subvl_in;
            ctx_mode   <= '{pen: pred_en, inv: pred_inv, zer: zeroing, ff: ffirst};
            ctx_mask   <= pred_mask;
            ctx_base   <= {rs2_in, rs1_in, rd_in};
            ctx_vec    <= {rs2_vec, rs1_vec, rd_vec};
        end
    end

    elseq_pred #(.XLEN(XLEN), .IDXW(IDXW)) u_pred (
        .mask   (ctx_mask),
        .idx    (idx),
        .mode   (ctx_mode),
        .active (pbit)
    );

    elseq_opgen #(.REGW(REGW), .IDXW(IDXW)) u_opgen (
        .base   (ctx_base),
        .vec    (ctx_vec),
        .idx    (idx),
        .sub    (sub),
        .subenc (ctx_subenc),
        .regs   (regs)
    );

    elseq_ctrl #(.XLEN(XLEN), .IDXW(IDXW), .VLW(VLW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vl_in       (vl_in),
        .ctx_vl      (ctx_vl),
        .ctx_subenc  (ctx_subenc),
        .ctx_mode    (ctx_mode),
        .pbit        (pbit),
        .ofs_wr      (ofs_wr),
        .ofs_wr_val  (ofs_wr_val),
        .issue_ready (issue_ready),
        .ex_zero     (ex_zero),
        .ex_fault    (ex_fault),
        .busy        (busy),
        .idx         (idx),
        .sub         (sub),
        .issue_valid (issue_valid),
        .op_zero     (op_zero),
        .done        (done),
        .trap        (trap),
        .vl_new      (vl_new),
        .vl_cut      (vl_cut)
    );

    always_comb begin
        pc_hold  = busy;
        op_rd    = regs[0];
        op_rs1   = regs[1];
        op_rs2   = regs[2];
        op_elem  = idx;
        op_sub   = sub;
        srcoffs  = idx;
        destoffs = idx;
    end

    // R5: zero-write operations only come from masked elements in zeroing mode
    p_zero_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op_zero) |-> (ctx_mode.zer && ctx_mode.pen));

    // R2: the element index of an offered operation lies inside the vector
    p_elem_range_r2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> ({1'b0, op_elem} < ctx_vl));

endmodule

// File: tb/elem_loop_seq_tb.sv
module elem_loop_seq_tb;
    localparam int XLEN = 32;
    localparam int REGW = 7;
    localparam int IDXW = 5;
    localparam int VLW  = 6;
    localparam int BRD  = 10;
    localparam int BRS1 = 20;
    localparam int BRS2 = 5;

    typedef struct packed {
        logic [5:0]  vl;
        logic [1:0]  se;
        logic        pen;
        logic [31:0] mask;
        logic        inv;
        logic        zer;
        logic        ff;
        logic [5:0]  zat;
        logic        st;
        logic [7:0]  iss;
        logic [7:0]  zr;
        logic [5:0]  evl;
        logic        cut;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{6'd4, 2'd0, 1'b0, 32'h0,      1'b0, 1'b0, 1'b0, 6'd63, 1'b0, 8'd4, 8'd0, 6'd4, 1'b0}, // R1 R2 R9
        '{6'd4, 2'd1, 1'b0, 32'h0,      1'b0, 1'b0, 1'b0, 6'd63, 1'b1, 8'd8, 8'd0, 6'd4, 1'b0}, // R7 R12
        '{6'd5, 2'd0, 1'b1, 32'b10110,  1'b0, 1'b0, 1'b0, 6'd63, 1'b0, 8'd3, 8'd0, 6'd5, 1'b0}, // R4
        '{6'd5, 2'd0, 1'b1, 32'b10110,  1'b1, 1'b0, 1'b0, 6'd63, 1'b1, 8'd2, 8'd0, 6'd5, 1'b0}, // R6
        '{6'd4, 2'd0, 1'b1, 32'b0101,   1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 8'd4, 8'd2, 6'd4, 1'b0}, // R5
        '{6'd6, 2'd0, 1'b0, 32'h0,      1'b0, 1'b0, 1'b1, 6'd3,  1'b0, 8'd4, 8'd0, 6'd3, 1'b1}, // R10
        '{6'd4, 2'd0, 1'b1, 32'b1011,   1'b0, 1'b1, 1'b1, 6'd63, 1'b0, 8'd2, 8'd0, 6'd2, 1'b1}, // R11
        '{6'd4, 2'd0, 1'b1, 32'b1010,   1'b0, 1'b0, 1'b1, 6'd0,  1'b0, 8'd2, 8'd0, 6'd4, 1'b0}, // R11
        '{6'd3, 2'd2, 1'b1, 32'b101,    1'b0, 1'b1, 1'b0, 6'd63, 1'b1, 8'd9, 8'd3, 6'd3, 1'b0}, // R7 R5
        '{6'd4, 2'd1, 1'b0, 32'h0,      1'b0, 1'b0, 1'b1, 6'd2,  1'b0, 8'd5, 8'd0, 6'd2, 1'b1}  // R10
    };

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [VLW-1:0] vl_in;
    logic [1:0] subvl_in;
    logic pred_en, pred_inv, zeroing, ffirst;
    logic [XLEN-1:0] pred_mask;
    logic [REGW-1:0] rd_in, rs1_in, rs2_in;
    logic rd_vec, rs1_vec, rs2_vec;
    logic ofs_wr;
    logic [IDXW-1:0] ofs_wr_val;
    logic issue_ready, ex_zero, ex_fault;
    logic pc_hold, issue_valid, op_zero, done, trap, vl_cut;
    logic [REGW-1:0] op_rd, op_rs1, op_rs2;
    logic [IDXW-1:0] op_elem, srcoffs, destoffs;
    logic [1:0] op_sub;
    logic [VLW-1:0] vl_new;

    always #4 clk = ~clk;

    elem_loop_seq #(.XLEN(XLEN), .REGW(REGW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .subvl_in(subvl_in),
        .pred_en(pred_en), .pred_inv(pred_inv), .zeroing(zeroing), .ffirst(ffirst),
        .pred_mask(pred_mask), .rd_in(rd_in), .rs1_in(rs1_in), .rs2_in(rs2_in),
        .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
        .ofs_wr(ofs_wr), .ofs_wr_val(ofs_wr_val),
        .issue_ready(issue_ready), .ex_zero(ex_zero), .ex_fault(ex_fault),
        .pc_hold(pc_hold), .issue_valid(issue_valid), .op_rd(op_rd), .op_rs1(op_rs1),
        .op_rs2(op_rs2), .op_elem(op_elem), .op_sub(op_sub), .op_zero(op_zero),
        .srcoffs(srcoffs), .destoffs(destoffs), .done(done), .trap(trap),
        .vl_new(vl_new), .vl_cut(vl_cut)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_iss, n_zr, first_elem, map_err, order_err, zero_err, stable_err, busy_err;
    bit saw_done, saw_trap, timed_out;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int vl, input int se, input bit pen, input logic [31:0] mask,
                       input bit inv, input bit zer, input bit ff, input int zat,
                       input int fat, input bit stall);
        int cyc;
        int s;
        int last_e;
        bit prev_stall;
        logic [REGW-1:0] p_rd;
        logic [IDXW-1:0] p_el;
        logic [1:0] p_sb;
        bit expz;
        s = se + 1;
        n_iss = 0; n_zr = 0; first_elem = -1; map_err = 0; order_err = 0;
        zero_err = 0; stable_err = 0; busy_err = 0; last_e = 0; prev_stall = 0;
        p_rd = '0; p_el = '0; p_sb = '0;
        vl_in = VLW'(vl); subvl_in = 2'(se); pred_en = pen; pred_mask = mask;
        pred_inv = inv; zeroing = zer; ffirst = ff;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!(done || trap)) begin
            if (!pc_hold) busy_err++;
            issue_ready = 1'b0; ex_zero = 1'b0; ex_fault = 1'b0;
            if (issue_valid) begin
                if (prev_stall && (op_rd != p_rd || op_elem != p_el || op_sub != p_sb))
                    stable_err++;
                issue_ready = !(stall && (cyc % 2 == 0));
                prev_stall = !issue_ready;
                p_rd = op_rd; p_el = op_elem; p_sb = op_sub;
                if (issue_ready) begin
                    n_iss++;
                    if (first_elem < 0) first_elem = int'(op_elem);
                    if (int'(op_elem) < last_e) order_err++;
                    last_e = int'(op_elem);
                    if (op_rd != REGW'(BRD + int'(op_elem) * s + int'(op_sub))) map_err++;
                    if (op_rs1 != REGW'(BRS1 + int'(op_elem) * s + int'(op_sub))) map_err++;
                    if (op_rs2 != REGW'(BRS2)) map_err++;
                    expz = pen && !(mask[op_elem] ^ inv);
                    if (op_zero) n_zr++;
                    if (op_zero != expz) zero_err++;
                    ex_zero = (int'(op_elem) == zat);
                    ex_fault = (int'(op_elem) == fat);
                end
            end else begin
                prev_stall = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 400) begin
                timed_out = 1'b1;
                break;
            end
        end
        issue_ready = 1'b0; ex_zero = 1'b0; ex_fault = 1'b0;
        saw_done = done;
        saw_trap = trap;
        chk(!timed_out, "R1 loop ended", int'(timed_out), 0);
        timed_out = 1'b0;
    endtask

    task automatic load_ofs(input int v);
        ofs_wr_val = IDXW'(v);
        ofs_wr = 1'b1;
        @(negedge clk);
        ofs_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        timed_out = 1'b0;
        rst = 1'b1; start = 1'b0; vl_in = VLW'(1); subvl_in = '0;
        pred_en = 0; pred_inv = 0; zeroing = 0; ffirst = 0; pred_mask = '0;
        rd_in = REGW'(BRD); rs1_in = REGW'(BRS1); rs2_in = REGW'(BRS2);
        rd_vec = 1; rs1_vec = 1; rs2_vec = 0;
        ofs_wr = 0; ofs_wr_val = '0; issue_ready = 0; ex_zero = 0; ex_fault = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(!pc_hold, "R1 reset hold", int'(pc_hold), 0);
        chk(!done && !trap, "R1 reset pulses", int'(done || trap), 0);
        chk(srcoffs == 0 && destoffs == 0, "R9 reset offsets", int'(srcoffs), 0);
        chk(!issue_valid, "R1 reset valid", int'(issue_valid), 0);

        for (int i = 0; i < NV; i++) begin
            run(int'(TBL[i].vl), int'(TBL[i].se), TBL[i].pen, TBL[i].mask, TBL[i].inv,
                TBL[i].zer, TBL[i].ff, int'(TBL[i].zat), 63, TBL[i].st);
            chk(saw_done && !saw_trap, "R1 done pulse", int'(saw_done), 1);
            chk(!pc_hold, "R1 hold released", int'(pc_hold), 0);
            chk(busy_err == 0, "R1 hold during loop", busy_err, 0);
            chk(n_iss == int'(TBL[i].iss), "R4 R7 R11 issue count", n_iss, int'(TBL[i].iss));
            chk(n_zr == int'(TBL[i].zr), "R5 zero ops", n_zr, int'(TBL[i].zr));
            chk(zero_err == 0, "R5 R6 zero flag per element", zero_err, 0);
            chk(map_err == 0, "R2 operand numbering", map_err, 0);
            chk(order_err == 0, "R7 issue order", order_err, 0);
            chk(stable_err == 0, "R12 stalled fields", stable_err, 0);
            chk(int'(vl_new) == int'(TBL[i].evl), "R9 R10 vl_new", int'(vl_new), int'(TBL[i].evl));
            chk(vl_cut == TBL[i].cut, "R10 vl_cut", int'(vl_cut), int'(TBL[i].cut));
            chk(srcoffs == 0 && destoffs == 0, "R9 offsets cleared", int'(srcoffs), 0);
            @(negedge clk);
            chk(!done, "R1 done one cycle", int'(done), 0);
        end

        // R8: fault on element 2 keeps the offset and raises trap
        run(5, 0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 63, 2, 1'b0);
        chk(saw_trap && !saw_done, "R8 trap not done", int'(saw_trap), 1);
        chk(int'(srcoffs) == 2 && int'(destoffs) == 2, "R8 offset kept", int'(srcoffs), 2);
        chk(!pc_hold, "R8 hold dropped", int'(pc_hold), 0);
        chk(n_iss == 3, "R8 issued before trap", n_iss, 3);
        @(negedge clk);

        // R3: reissue resumes at the kept offset
        run(5, 0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 63, 63, 1'b0);
        chk(first_elem == 2, "R3 resume element", first_elem, 2);
        chk(n_iss == 3, "R3 resumed count", n_iss, 3);
        chk(saw_done && int'(vl_new) == 5, "R9 resumed completion", int'(vl_new), 5);
        @(negedge clk);

        // R3: offset loaded while idle
        load_ofs(3);
        chk(int'(srcoffs) == 3 && int'(destoffs) == 3, "R3 offset load", int'(srcoffs), 3);
        run(5, 0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 63, 63, 1'b0);
        chk(first_elem == 3, "R3 loaded start", first_elem, 3);
        chk(n_iss == 2, "R3 loaded count", n_iss, 2);
        @(negedge clk);

        // R3: offset beyond VL is clamped to VL-1
        load_ofs(7);
        run(4, 0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 63, 63, 1'b0);
        chk(first_elem == 3, "R3 clamped start", first_elem, 3);
        chk(n_iss == 1, "R3 clamped count", n_iss, 1);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule